// File: doc/BRIEF.md
# Trace-Capturing SRAM Controller

This block lets the system bus and a processor's program-flow trace share one single-port SRAM. To any AHB-Lite master it looks like ordinary RAM with byte, halfword and word lanes and no wait states. Tracing can be switched on from software or by two trigger pulses. While tracing is on, every branch event from the trace input is kept as a pair of words: the address the flow left from, then the address it went to. These pairs are written into a window of the same memory, and that window wraps around.

The memory has only one port, and a pending record write always gets it first. A bus access that collides with a record write is held with `hreadyout` low until the port is free. A small register bank in a second AHB-Lite select region sets the window size and base, shows the write pointer, and holds the tracing-enabled bit. A debugger reads the captured pairs back over the bus.

Top module: `trace_sram_ctrl`

## Requirements
- R1: After reset `hreadyout` is 1, tracing is off, and the control, base and pointer registers all read 0.
- R2: With no record being written, memory accesses complete with no wait state. `hsize` 0 selects a byte, 1 a halfword and 2 a word. Lanes are little-endian and chosen by `haddr[1:0]`, so byte k of a word sits on bits 8k+7:8k.
- R3: Each record takes the memory port for two cycles. A memory data phase that meets a pending record write waits with `hreadyout` low, and its address stays captured. One record stalls a colliding read for 2 cycles, and two back-to-back records stall it for 4.
- R4: A record is stored as the source word at the pointer and the destination word at pointer+4. The pointer then advances by 8.
- R5: The window holds 16 << SIZE bytes, starting at BASE. When pointer+8 reaches or passes BASE+window, the pointer returns to BASE and WRAP is set. WRAP is sticky until the pointer register is written.
- R6: The register select region is word-wide. Offset 0x0 is CTRL: bit 0 ENABLE, bits 7:4 SIZE, bit 31 WRAP (read-only). Offset 0x4 is BASE and offset 0x8 is POINTER. Bits 2:0 of BASE and POINTER always read 0, and offset 0xC reads 0. Register accesses have no wait state.
- R7: A `trig_start` pulse sets ENABLE and a `trig_stop` pulse clears it. When both arrive in the same cycle, ENABLE ends up cleared.
- R8: An event is accepted only when ENABLE is 1 in its cycle. Events arriving while ENABLE is 0 leave the pointer and memory untouched. An event accepted in the same cycle as a stop is still written out in full.
- R9: The block holds at most two records: the one being written and one waiting. An event is accepted when fewer than two records remain after any record that finishes in that cycle. Of four events on consecutive cycles, the first three are stored and the fourth is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel_mem | input | 1 | Selects the memory region |
| hsel_reg | input | 1 | Selects the register region |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | Write when 1 |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-level ready, closes an address phase |
| hreadyout | output | 1 | Low while a memory data phase is stalled |
| hresp | output | 1 | Always OKAY (0) |
| hrdata | output | 32 | Read data |
| trc_valid | input | 1 | Branch event strobe |
| trc_src | input | 32 | Address the flow left from |
| trc_dst | input | 32 | Address the flow went to |
| trig_start | input | 1 | Start-tracing pulse |
| trig_stop | input | 1 | Stop-tracing pulse |

## Verification
Bus traffic is first run with no events, which shows that lane merging and the zero-wait path work by themselves. Reads are then lined up with one event and with two events in consecutive cycles. The 2-cycle and 4-cycle stalls show that the port is held for each record word and that the waiting record follows straight after the first. A burst of four events tells whether the holding buffer fills at exactly two records. Events placed on the same edge as the triggers, or as an ENABLE clear, separate the acceptance decision from record drain. Placing records on the last slot of a small window tests the wrap compare and the sticky flag.

// File: rtl/trace_sram_ctrl.sv
`timescale 1ns/1ps
module trace_sram_ctrl #(
  parameter int MEM_WORDS = 1024
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel_mem,
  input  logic        hsel_reg,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [31:0] hwdata,
  input  logic        hready,
  output logic        hreadyout,
  output logic        hresp,
  output logic [31:0] hrdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_src,
  input  logic [31:0] trc_dst,
  input  logic        trig_start,
  input  logic        trig_stop
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [31:0] mem [MEM_WORDS];

  logic        dp_mem, dp_reg, dp_wr;
  logic [31:0] dp_addr;
  logic [3:0]  dp_lanes, ap_lanes;

  logic        active, wrap;
  logic [3:0]  size_code;
  logic [31:0] base, ptr;

  logic        cur_v, cur_half, buf_v;
  logic [31:0] cur_src, cur_dst, buf_src, buf_dst;

  wire ap_go    = hready & htrans[1];
  wire rec_done = cur_v & cur_half;
  wire accept   = trc_valid & active & (~buf_v | rec_done);

  wire wr_ctrl = dp_reg & dp_wr & (dp_addr[3:2] == 2'd0);
  wire wr_base = dp_reg & dp_wr & (dp_addr[3:2] == 2'd1);
  wire wr_ptr  = dp_reg & dp_wr & (dp_addr[3:2] == 2'd2);

  wire [31:0] ptr_nxt = ptr + 32'd8;
  wire [31:0] win_end = base + (32'd16 << size_code);
  wire        at_end  = ptr_nxt >= win_end;

  wire [AW-1:0] trc_idx = {ptr[AW+1:3], cur_half};
  wire [AW-1:0] dp_idx  = dp_addr[AW+1:2];

  assign hreadyout = ~(dp_mem & cur_v);
  assign hresp     = 1'b0;

  always_comb begin
    case (hsize)
      3'd0:    ap_lanes = 4'b0001 << haddr[1:0];
      3'd1:    ap_lanes = haddr[1] ? 4'b1100 : 4'b0011;
      default: ap_lanes = 4'b1111;
    endcase
  end

  always_comb begin
    if (dp_reg) begin
      case (dp_addr[3:2])
        2'd0:    hrdata = {wrap, 23'd0, size_code, 3'd0, active};
        2'd1:    hrdata = base;
        2'd2:    hrdata = ptr;
        default: hrdata = 32'd0;
      endcase
    end else begin
      hrdata = mem[dp_idx];
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_mem   <= 1'b0;
      dp_reg   <= 1'b0;
      dp_wr    <= 1'b0;
      dp_addr  <= '0;
      dp_lanes <= '0;
    end else if (hready) begin
      dp_mem   <= hsel_mem & ap_go;
      dp_reg   <= hsel_reg & ap_go;
      dp_wr    <= hwrite;
      dp_addr  <= haddr;
      dp_lanes <= ap_lanes;
    end
  end

  always_ff @(posedge hclk) begin
    if (cur_v) begin
      mem[trc_idx] <= cur_half ? cur_dst : cur_src;
    end else if (dp_mem && dp_wr) begin
      for (int b = 0; b < 4; b++)
        if (dp_lanes[b]) mem[dp_idx][8*b +: 8] <= hwdata[8*b +: 8];
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      active    <= 1'b0;
      size_code <= '0;
      base      <= '0;
      ptr       <= '0;
      wrap      <= 1'b0;
    end else begin
      if (trig_stop)       active <= 1'b0;
      else if (trig_start) active <= 1'b1;
      else if (wr_ctrl)    active <= hwdata[0];
      if (wr_ctrl) size_code <= hwdata[7:4];
      if (wr_base) base <= {hwdata[31:3], 3'd0};
      if (wr_ptr) begin
        ptr  <= {hwdata[31:3], 3'd0};
        wrap <= 1'b0;
      end else if (rec_done) begin
        ptr <= at_end ? base : ptr_nxt;
        if (at_end) wrap <= 1'b1;
      end
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      cur_v    <= 1'b0;
      cur_half <= 1'b0;
      buf_v    <= 1'b0;
      cur_src  <= '0;
      cur_dst  <= '0;
      buf_src  <= '0;
      buf_dst  <= '0;
    end else if (rec_done && buf_v) begin
      cur_src  <= buf_src;
      cur_dst  <= buf_dst;
      cur_half <= 1'b0;
      buf_v    <= accept;
      if (accept) begin
        buf_src <= trc_src;
        buf_dst <= trc_dst;
      end
    end else if (cur_v && !rec_done) begin
      cur_half <= 1'b1;
      if (accept) begin
        buf_v   <= 1'b1;
        buf_src <= trc_src;
        buf_dst <= trc_dst;
      end
    end else begin
      cur_v    <= accept;
      cur_half <= 1'b0;
      if (accept) begin
        cur_src <= trc_src;
        cur_dst <= trc_dst;
      end
    end
  end
endmodule

// File: rtl/trace_sram_ctrl_chk.sv
`timescale 1ns/1ps
module trace_sram_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hreadyout,
  input logic        dp_mem,
  input logic [31:0] dp_addr,
  input logic        cur_v,
  input logic        cur_half,
  input logic        buf_v,
  input logic        wr_ptr,
  input logic [31:0] ptr,
  input logic [31:0] base,
  input logic        wrap,
  input logic        active,
  input logic        trig_start,
  input logic        trig_stop
);
  assert_wait_only_on_trace_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |-> cur_v);

  assert_stall_keeps_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |=> dp_mem && $stable(dp_addr));

  assert_trace_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_mem && cur_v |-> !hreadyout);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v && cur_half && !wr_ptr |=> (ptr == $past(ptr) + 32'd8) || (ptr == $past(base)));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_v && cur_half) && !wr_ptr |=> $stable(ptr));

  assert_wrap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !wr_ptr |=> wrap);

  assert_stop_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stop |=> !active);

  assert_start_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_start && !trig_stop |=> active);

  assert_idle_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !cur_v |=> !cur_v);

  assert_buffer_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_v |-> cur_v);
endmodule

bind trace_sram_ctrl trace_sram_ctrl_chk i_chk (
  .clk(hclk), .rst_n(hresetn), .hreadyout(hreadyout), .dp_mem(dp_mem),
  .dp_addr(dp_addr), .cur_v(cur_v), .cur_half(cur_half), .buf_v(buf_v),
  .wr_ptr(wr_ptr), .ptr(ptr), .base(base), .wrap(wrap), .active(active),
  .trig_start(trig_start), .trig_stop(trig_stop)
);

// File: tb/test_trace_sram_ctrl.sv
`timescale 1ns/1ps
module test_trace_sram_ctrl;
  localparam int W = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsel_mem = 0, hsel_reg = 0, hwrite = 0;
  logic [31:0] haddr = 0, hwdata = 0, hrdata;
  logic [1:0] htrans = 0;
  logic [2:0] hsize = 0;
  logic hreadyout, hresp;
  logic trc_valid = 0, trig_start = 0, trig_stop = 0;
  logic [31:0] trc_src = 0, trc_dst = 0;

  always #10 clk = ~clk;

  trace_sram_ctrl #(.MEM_WORDS(W)) i_trace_sram_ctrl (
    .hclk(clk), .hresetn(rst_n), .hsel_mem(hsel_mem), .hsel_reg(hsel_reg),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hwdata(hwdata), .hready(hreadyout), .hreadyout(hreadyout), .hresp(hresp),
    .hrdata(hrdata), .trc_valid(trc_valid), .trc_src(trc_src), .trc_dst(trc_dst),
    .trig_start(trig_start), .trig_stop(trig_stop));

  int tests = 0, fails = 0;
  string req = "R1";

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  // Reference model
  logic [31:0] m_mem [int];
  logic [63:0] m_q [$];
  bit m_half, m_active, m_wrap, m_dp_mem, m_dp_reg, m_dp_wr;
  logic [3:0] m_size, m_lanes;
  logic [31:0] m_base, m_ptr, m_dp_addr;

  function automatic bit m_ready();
    return !(m_dp_mem && m_q.size() > 0);
  endfunction

  function automatic logic [31:0] m_regval(logic [31:0] a);
    case (a[3:2])
      2'd0: return {m_wrap, 23'd0, m_size, 3'd0, m_active};
      2'd1: return m_base;
      2'd2: return m_ptr;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_half = 0; m_active = 0; m_wrap = 0; m_size = 0;
      m_base = 0; m_ptr = 0; m_dp_mem = 0; m_dp_reg = 0; m_dp_wr = 0;
      m_dp_addr = 0; m_lanes = 0;
    end else begin
      automatic bit rdy = m_ready();
      automatic bit busy = m_q.size() > 0;
      automatic bit done = busy && m_half;
      automatic int left = m_q.size() - (done ? 1 : 0);
      automatic bit acc = trc_valid && m_active && left < 2;
      automatic bit wc = m_dp_reg && m_dp_wr && m_dp_addr[3:2] == 2'd0;
      automatic bit wb = m_dp_reg && m_dp_wr && m_dp_addr[3:2] == 2'd1;
      automatic bit wp = m_dp_reg && m_dp_wr && m_dp_addr[3:2] == 2'd2;
      automatic logic [31:0] nxt = m_ptr + 32'd8;
      automatic logic [31:0] wend = m_base + (32'd16 << m_size);
      if (busy) begin
        automatic int idx = ((m_ptr >> 2) + m_half) % W;
        m_mem[idx] = m_half ? m_q[0][31:0] : m_q[0][63:32];
      end else if (m_dp_mem && m_dp_wr) begin
        automatic int idx = (m_dp_addr >> 2) % W;
        automatic logic [31:0] w = m_mem.exists(idx) ? m_mem[idx] : 32'd0;
        for (int b = 0; b < 4; b++) if (m_lanes[b]) w[8*b +: 8] = hwdata[8*b +: 8];
        m_mem[idx] = w;
      end
      if (wp) begin
        m_ptr = {hwdata[31:3], 3'd0}; m_wrap = 0;
      end else if (done) begin
        if (nxt >= wend) begin m_ptr = m_base; m_wrap = 1; end
        else m_ptr = nxt;
      end
      if (done) begin void'(m_q.pop_front()); m_half = 0; end
      else if (busy) m_half = 1;
      if (acc) m_q.push_back({trc_src, trc_dst});
      if (trig_stop) m_active = 0;
      else if (trig_start) m_active = 1;
      else if (wc) m_active = hwdata[0];
      if (wc) m_size = hwdata[7:4];
      if (wb) m_base = {hwdata[31:3], 3'd0};
      if (rdy) begin
        m_dp_mem = hsel_mem && htrans[1];
        m_dp_reg = hsel_reg && htrans[1];
        m_dp_wr = hwrite;
        m_dp_addr = haddr;
        case (hsize)
          3'd0: m_lanes = 4'b0001 << haddr[1:0];
          3'd1: m_lanes = haddr[1] ? 4'b1100 : 4'b0011;
          default: m_lanes = 4'b1111;
        endcase
      end
    end
  end

  // Per-cycle comparison, sampled away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      automatic bit rdy = m_ready();
      chk({req, " hreadyout"}, {31'd0, hreadyout}, {31'd0, rdy});
      if (rdy && !m_dp_wr && m_dp_reg)
        chk({req, " reg read"}, hrdata, m_regval(m_dp_addr));
      if (rdy && !m_dp_wr && m_dp_mem && m_mem.exists((m_dp_addr >> 2) % W))
        chk({req, " mem read"}, hrdata, m_mem[(m_dp_addr >> 2) % W]);
    end
  end

  // Stimulus tasks, all entered at a falling edge
  task automatic bus(bit rsp, bit wr, logic [31:0] a, logic [2:0] sz,
                     logic [31:0] wd, output logic [31:0] rd, output int stalls);
    hsel_mem = !rsp; hsel_reg = rsp; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
    while (!hreadyout) @(negedge clk);
    @(negedge clk);
    hsel_mem = 0; hsel_reg = 0; htrans = 2'b00; hwdata = wd; stalls = 0;
    while (!hreadyout) begin stalls++; @(negedge clk); end
    rd = hrdata;
    @(negedge clk);
  endtask

  task automatic wreg(logic [31:0] a, logic [31:0] d);
    logic [31:0] r; int s;
    bus(1, 1, a, 3'd2, d, r, s);
  endtask

  task automatic rreg(logic [31:0] a, output logic [31:0] d);
    int s;
    bus(1, 0, a, 3'd2, 32'd0, d, s);
  endtask

  task automatic rmem(logic [31:0] a, output logic [31:0] d);
    int s;
    bus(0, 0, a, 3'd2, 32'd0, d, s);
  endtask

  task automatic ev(logic [31:0] s, logic [31:0] d);
    trc_valid = 1; trc_src = s; trc_dst = d;
    @(negedge clk);
    trc_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    req = "R1";
    chk("R1 ready", {31'd0, hreadyout}, 32'd1);
    rreg(32'h0, r); chk("R1 ctrl", r, 32'h0);
    rreg(32'h4, r); chk("R1 base", r, 32'h0);
    rreg(32'h8, r); chk("R1 ptr", r, 32'h0);

    req = "R2";
    bus(0, 1, 32'h40, 3'd2, 32'h11223344, r, st); chk("R2 word stalls", st, 0);
    bus(0, 1, 32'h41, 3'd0, {4{8'hAA}}, r, st);   chk("R2 byte stalls", st, 0);
    bus(0, 1, 32'h42, 3'd1, {2{16'hBEEF}}, r, st);
    bus(0, 0, 32'h40, 3'd2, 32'd0, r, st);
    chk("R2 lanes", r, 32'hBEEFAA44); chk("R2 read stalls", st, 0);

    req = "R6";
    wreg(32'h4, 32'h200);
    wreg(32'h8, 32'h205);
    wreg(32'h0, 32'h41);
    rreg(32'h4, r); chk("R6 base", r, 32'h200);
    rreg(32'h8, r); chk("R6 ptr aligned", r, 32'h200);
    rreg(32'h0, r); chk("R6 ctrl", r, 32'h41);
    rreg(32'hC, r); chk("R6 spare", r, 32'h0);

    req = "R4";
    ev(32'h1000, 32'h2000); idle(4);
    rmem(32'h200, r); chk("R4 src", r, 32'h1000);
    rmem(32'h204, r); chk("R4 dst", r, 32'h2000);
    rreg(32'h8, r); chk("R4 ptr", r, 32'h208);

    req = "R3";
    fork
      bus(0, 0, 32'h40, 3'd2, 32'd0, r, st);
      ev(32'h11110000, 32'h22220000);
    join
    chk("R3 one record stall", st, 2); chk("R3 data", r, 32'hBEEFAA44);
    idle(2);
    fork
      bus(0, 0, 32'h40, 3'd2, 32'd0, r, st);
      begin ev(32'h33330000, 32'h44440000); ev(32'h55550000, 32'h66660000); end
    join
    chk("R3 two record stall", st, 4);
    idle(4);
    rreg(32'h8, r); chk("R3 ptr", r, 32'h220);
    rmem(32'h218, r); chk("R3 second record", r, 32'h55550000);

    req = "R9";
    for (int i = 0; i < 4; i++) ev(32'hA0 + i, 32'hB0 + i);
    idle(8);
    rreg(32'h8, r); chk("R9 three kept", r, 32'h238);
    rmem(32'h230, r); chk("R9 third src", r, 32'hA2);
    rmem(32'h234, r); chk("R9 third dst", r, 32'hB2);

    req = "R8";
    wreg(32'h0, 32'h40);
    ev(32'hDEAD, 32'hBEEF); idle(4);
    rreg(32'h8, r); chk("R8 disabled ignored", r, 32'h238);

    req = "R7";
    trig_start = 1; @(negedge clk); trig_start = 0;
    rreg(32'h0, r); chk("R7 start", r, 32'h41);
    trig_stop = 1; trc_valid = 1; trc_src = 32'hC0; trc_dst = 32'hC4;
    @(negedge clk);
    trig_stop = 0; trc_valid = 0;
    idle(4);
    rreg(32'h0, r); chk("R7 stop", r, 32'h40);
    rreg(32'h8, r); chk("R8 drain after stop", r, 32'h240);
    trig_start = 1; trig_stop = 1; @(negedge clk); trig_start = 0; trig_stop = 0;
    rreg(32'h0, r); chk("R7 stop wins", r, 32'h40);

    req = "R5";
    wreg(32'h4, 32'h300);
    wreg(32'h8, 32'h310);
    wreg(32'h0, 32'h11);
    ev(32'hE0, 32'hE4); idle(4);
    rreg(32'h8, r); chk("R5 before end", r, 32'h318);
    ev(32'hF0, 32'hF4); idle(4);
    rreg(32'h8, r); chk("R5 wrapped ptr", r, 32'h300);
    rreg(32'h0, r); chk("R5 wrap flag", r, 32'h80000011);
    rmem(32'h318, r); chk("R5 last slot src", r, 32'hF0);
    rmem(32'h31C, r); chk("R5 last slot dst", r, 32'hF4);
    ev(32'h1F0, 32'h1F4); idle(4);
    rreg(32'h8, r); chk("R5 after wrap", r, 32'h308);
    rreg(32'h0, r); chk("R5 sticky", r, 32'h80000011);
    wreg(32'h8, 32'h300);
    rreg(32'h0, r); chk("R5 flag cleared", r, 32'h11);

    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule